// File: doc/BRIEF.md
# Timestamp and Pulse-Generator Timebase

This block runs on a 19.2 MHz reference clock and keeps a free-running 56-bit count of its cycles. Three coarse timestamps for three consumers (a tag stamp, an address-translation stamp and a logging stamp) are taken from that count. Each is the count shifted right by its own programmable amount, truncated to 32 bits. The logging stamp can instead show a legacy count of whole milliseconds.

A programmable divider turns the reference into a one-cycle common timer enable. The divider has its own enable bit, and software turns it off while it changes the ratio. Three pulse generators count common ticks, and each emits a one-cycle pulse at its own selectable granularity. Downstream timeout timers use these pulses. All configuration arrives through a one-cycle register write port with three word addresses.

Top module: `tbu_timebase`

## Requirements
- R1: `ts_raw` is zero while `rst` is high and grows by exactly one on every clock edge after reset.
- R2: A write to address 1 sets the tag shift from bits [5:0] and the translation shift from bits [13:8]. `ts_tag` and `ts_nat` equal the low 32 bits of `ts_raw` shifted right by the matching amount, and a shift above 55 gives zero.
- R3: Address 1 bit 24 selects the source of the logging stamp. When it is 1, `ts_log` is `ts_raw` shifted right by bits [21:16], with the same rule as R2. When it is 0, `ts_log` is the number of whole milliseconds since reset, where one millisecond is 19200 clocks.
- R4: A write to address 0 loads the divider value from bits [15:0] and the divider enable from bit 31. While the stored enable is 0, `common_tick` stays low.
- R5: With divider value V, the first `common_tick` comes N = V+1 clocks after the cycle in which the stored enable first reads 1. It then repeats every N clocks, one cycle wide each time, and V = 0 gives a tick on every cycle.
- R6: A write to address 2 sets the granularity of generator g from bits [2g+1:2g]. The codes 0, 1, 2 and 3 give L = 1, 10, 100 and 1000 common ticks. `pulse[g]` is high for one cycle, in the cycle after every L-th common tick counted since the generator last restarted.
- R7: A generator whose granularity field changes value restarts its count from zero, and its pulse is low in the cycle after the write even if a tick coincided with the write. A generator whose field is written with its current value keeps counting without interruption.
- R8: A write to address 3 has no effect on any output.
- R9: Out of reset all stamps read zero, the divider is off, `common_tick` and `pulse` are low, every shift is zero and the logging stamp shows the millisecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.2 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| ts_raw | output | 56 | Free-running reference count |
| ts_log | output | 32 | Logging stamp (shifted count or milliseconds) |
| ts_tag | output | 32 | Tag stamp |
| ts_nat | output | 32 | Address-translation stamp |
| common_tick | output | 1 | Divided common timer enable |
| pulse | output | 3 | Per-generator granularity pulses |

## Verification
The bench sets a shift of 63 and a shift of 56 to catch a shifter that wraps the shift amount instead of clearing the result. It also sets shift zero, which shows a truncation off by one bit. It times the first common tick after the divider is enabled and uses a ratio of one, so a divider that counts from one or misses the value-zero case drifts by a cycle. It changes one granularity field while another stays the same, then writes an unchanged word. A design that restarts every generator, or none, would produce shifted or extra pulses. The bench also disables the divider in the middle of a run, writes to the unused address, and runs past several millisecond boundaries so that a wrong legacy prescaler shows up.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

   localparam logic [1:0] ADDR_DIV  = 2'd0;
   localparam logic [1:0] ADDR_TS   = 2'd1;
   localparam logic [1:0] ADDR_GRAN = 2'd2;

   localparam int DIV_EN_BIT   = 31;
   localparam int LOG_SEL_BIT  = 24;
   localparam int TS_FIELD_GAP = 8;
   localparam int GRAN_FIELD_W = 2;

   // consumer index order inside the shift array
   localparam int CONS_TAG = 0;
   localparam int CONS_NAT = 1;
   localparam int CONS_LOG = 2;
   localparam int N_CONS   = 3;

   typedef enum logic [1:0] {
      GRAN_10US  = 2'd0,
      GRAN_100US = 2'd1,
      GRAN_1MS   = 2'd2,
      GRAN_10MS  = 2'd3
   } gran_e;

   // number of common ticks per pulse: ten to the power of the code
   function automatic int unsigned gran_limit(input logic [1:0] code);
      int unsigned lim;
      lim = 1;
      for (int k = 0; k < 3; k++) begin
         if (k < int'(code)) lim = lim * 10;
      end
      return lim;
   endfunction

endpackage

// File: rtl/tbu_ts_shift.sv
module tbu_ts_shift #(
   parameter int TS_W    = 56,
   parameter int OUT_W   = 32,
   parameter int SHIFT_W = 6
) (
   input  logic [TS_W-1:0]    ts,
   input  logic [SHIFT_W-1:0] shift,
   output logic [OUT_W-1:0]   stamp
);

   generate
      if (OUT_W > TS_W) begin : g_bad_width
         $error("tbu_ts_shift: OUT_W must not exceed TS_W");
      end
   endgenerate

   logic [TS_W-1:0] shifted;

   always_comb begin
      shifted = ts >> shift;
      if (int'(shift) > TS_W - 1) begin
         stamp = '0;
      end else begin
         stamp = shifted[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/tbu_divider.sv
module tbu_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DIV_W-1:0] ratio_m1,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= ratio_m1) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/tbu_pulse_gen.sv
module tbu_pulse_gen
   import tbu_pkg::*;
#(
   parameter int GCNT_W = 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] gran,
   output logic       pulse
);

   generate
      if ((1 << GCNT_W) < 1000) begin : g_bad_cnt
         $error("tbu_pulse_gen: GCNT_W too small for the longest granularity");
      end
   endgenerate

   logic [GCNT_W-1:0] cnt;
   logic [GCNT_W-1:0] last;

   assign last = GCNT_W'(gran_limit(gran) - 1);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt   <= '0;
         pulse <= 1'b0;
      end else if (tick) begin
         if (cnt >= last) begin
            cnt   <= '0;
            pulse <= 1'b1;
         end else begin
            cnt   <= cnt + 1'b1;
            pulse <= 1'b0;
         end
      end else begin
         pulse <= 1'b0;
      end
   end

endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
   import tbu_pkg::*;
#(
   parameter int TS_W       = 56,
   parameter int OUT_W      = 32,
   parameter int SHIFT_W    = 6,
   parameter int DIV_W      = 16,
   parameter int N_GEN      = 3,
   parameter int GCNT_W     = 10,
   parameter int REF_PER_MS = 19200
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [31:0]       wr_data,
   output logic [TS_W-1:0]   ts_raw,
   output logic [OUT_W-1:0]  ts_log,
   output logic [OUT_W-1:0]  ts_tag,
   output logic [OUT_W-1:0]  ts_nat,
   output logic              common_tick,
   output logic [N_GEN-1:0]  pulse
);

   localparam int PRE_W  = $clog2(REF_PER_MS);
   localparam int GRAN_W = N_GEN * GRAN_FIELD_W;

   generate
      if (GRAN_W > 32) begin : g_bad_gen
         $error("tbu_timebase: too many generators for one register");
      end
      if (DIV_W > DIV_EN_BIT) begin : g_bad_div
         $error("tbu_timebase: divider field overlaps its enable bit");
      end
      if (SHIFT_W > TS_FIELD_GAP) begin : g_bad_shift
         $error("tbu_timebase: shift field wider than its slot");
      end
   endgenerate

   // register write decode
   logic wr_div, wr_ts, wr_gran;
   assign wr_div  = wr_en && (wr_addr == ADDR_DIV);
   assign wr_ts   = wr_en && (wr_addr == ADDR_TS);
   assign wr_gran = wr_en && (wr_addr == ADDR_GRAN);

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   logic               div_en_q;
   logic [DIV_W-1:0]   div_val_q;
   logic [SHIFT_W-1:0] sh_q [N_CONS];
   logic               log_sel_q;
   logic [GRAN_W-1:0]  gran_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_en_q  <= 1'b0;
         div_val_q <= '0;
         log_sel_q <= 1'b0;
         gran_q    <= '0;
         for (int c = 0; c < N_CONS; c++) sh_q[c] <= '0;
      end else begin
         if (wr_div) begin
            div_en_q  <= wr_data[DIV_EN_BIT];
            div_val_q <= wr_data[DIV_W-1:0];
         end
         if (wr_ts) begin
            log_sel_q <= wr_data[LOG_SEL_BIT];
            for (int c = 0; c < N_CONS; c++)
               sh_q[c] <= wr_data[c*TS_FIELD_GAP +: SHIFT_W];
         end
         if (wr_gran) gran_q <= wr_data[GRAN_W-1:0];
      end
   end

   // free-running reference count and legacy millisecond count
   logic [TS_W-1:0]  raw_q;
   logic [PRE_W-1:0] ms_pre_q;
   logic [OUT_W-1:0] ms_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_q    <= '0;
         ms_pre_q <= '0;
         ms_q     <= '0;
      end else begin
         raw_q <= raw_q + 1'b1;
         if (ms_pre_q == PRE_W'(REF_PER_MS - 1)) begin
            ms_pre_q <= '0;
            ms_q     <= ms_q + 1'b1;
         end else begin
            ms_pre_q <= ms_pre_q + 1'b1;
         end
      end
   end

   assign ts_raw = raw_q;

   // coarse stamps
   logic [OUT_W-1:0] stamp [N_CONS];

   generate
      for (genvar c = 0; c < N_CONS; c++) begin : g_cons
         tbu_ts_shift #(
            .TS_W    (TS_W),
            .OUT_W   (OUT_W),
            .SHIFT_W (SHIFT_W)
         ) shift_i (
            .ts    (raw_q),
            .shift (sh_q[c]),
            .stamp (stamp[c])
         );
      end
   endgenerate

   assign ts_tag = stamp[CONS_TAG];
   assign ts_nat = stamp[CONS_NAT];
   assign ts_log = log_sel_q ? stamp[CONS_LOG] : ms_q;

   // common divider
   tbu_divider #(
      .DIV_W (DIV_W)
   ) div_i (
      .clk      (clk),
      .rst      (rst),
      .en       (div_en_q),
      .ratio_m1 (div_val_q),
      .tick     (common_tick)
   );

   // pulse generators
   generate
      for (genvar g = 0; g < N_GEN; g++) begin : g_gen
         logic [1:0] new_code;
         logic       restart;
         assign new_code = wr_data[g*GRAN_FIELD_W +: GRAN_FIELD_W];
         assign restart  = wr_gran &&
                           (new_code != gran_q[g*GRAN_FIELD_W +: GRAN_FIELD_W]);
         tbu_pulse_gen #(
            .GCNT_W (GCNT_W)
         ) pg_i (
            .clk     (clk),
            .rst     (rst),
            .tick    (common_tick),
            .restart (restart),
            .gran    (gran_q[g*GRAN_FIELD_W +: GRAN_FIELD_W]),
            .pulse   (pulse[g])
         );
      end
   endgenerate

endmodule

// File: rtl/tbu_timebase_chk.sv
module tbu_timebase_chk
   import tbu_pkg::*;
#(
   parameter int TS_W    = 56,
   parameter int OUT_W   = 32,
   parameter int SHIFT_W = 6,
   parameter int N_GEN   = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    wr_en,
   input logic [1:0]              wr_addr,
   input logic [31:0]             wr_data,
   input logic [TS_W-1:0]         ts_raw,
   input logic [OUT_W-1:0]        ts_tag,
   input logic                    common_tick,
   input logic [N_GEN-1:0]        pulse,
   input logic [SHIFT_W-1:0]      tag_sh,
   input logic [N_GEN*2-1:0]      gran_q
);

   logic live;
   always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
   end

   a_r1_raw_step: assert property (@(posedge clk) disable iff (rst)
      live |-> ts_raw == $past(ts_raw) + 1'b1);

   a_r2_wide_shift_zero: assert property (@(posedge clk) disable iff (rst)
      (int'(tag_sh) > TS_W - 1) |-> ts_tag == '0);

   a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_DIV && !wr_data[DIV_EN_BIT]) |=> ##1 !common_tick);

   a_r6_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
      (|pulse) |-> $past(common_tick));

   generate
      for (genvar g = 0; g < N_GEN; g++) begin : g_restart
         a_r7_restart_quiet: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_GRAN &&
             wr_data[2*g +: 2] != gran_q[2*g +: 2]) |=> !pulse[g]);
      end
   endgenerate

endmodule

bind tbu_timebase tbu_timebase_chk #(
   .TS_W    (TS_W),
   .OUT_W   (OUT_W),
   .SHIFT_W (SHIFT_W),
   .N_GEN   (N_GEN)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .ts_raw      (ts_raw),
   .ts_tag      (ts_tag),
   .common_tick (common_tick),
   .pulse       (pulse),
   .tag_sh      (sh_q[0]),
   .gran_q      (gran_q)
);

// File: tb/tbu_timebase_tb_top.sv
module tbu_timebase_tb_top;

   localparam time CLK_PERIOD = 52ns;
   localparam int  REF_MS     = 19200;
   localparam int  WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;

   logic [55:0] ts_raw;
   logic [31:0] ts_log, ts_tag, ts_nat;
   logic        common_tick;
   logic [2:0]  pulse;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tbu_timebase dut_i (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ts_raw      (ts_raw),
      .ts_log      (ts_log),
      .ts_tag      (ts_tag),
      .ts_nat      (ts_nat),
      .common_tick (common_tick),
      .pulse       (pulse)
   );

   int    n_cmp  = 0;
   int    n_bad  = 0;
   int    cycles = 0;
   bit    done   = 1'b0;
   string phase  = "R9";

   // behavioural model state
   longint unsigned m_raw;
   bit  m_en;
   int  m_val;
   int  m_since;
   bit  m_tick;
   int  m_seen  [3];
   bit  m_pulse [3];
   int  m_gran  [3];
   int  m_sh    [3];
   bit  m_sel;

   function automatic int lim_of(input int code);
      case (code)
         0: return 1;
         1: return 10;
         2: return 100;
         default: return 1000;
      endcase
   endfunction

   function automatic longint unsigned stamp_of(input longint unsigned raw, input int sh);
      if (sh > 55) return 0;
      return (raw >> sh) & 64'hFFFF_FFFF;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_raw = 0; m_en = 0; m_val = 0; m_since = 0; m_tick = 0; m_sel = 0;
         for (int g = 0; g < 3; g++) begin
            m_seen[g] = 0; m_pulse[g] = 0; m_gran[g] = 0; m_sh[g] = 0;
         end
      end else begin
         bit old_tick;
         old_tick = m_tick;
         m_raw++;
         if (m_en) begin
            m_since++;
            m_tick = ((m_since % (m_val + 1)) == 0);
         end else begin
            m_tick = 0;
         end
         for (int g = 0; g < 3; g++) begin
            if (wr_en && wr_addr == 2'd2 && int'(wr_data[2*g +: 2]) != m_gran[g]) begin
               m_seen[g] = 0;
               m_pulse[g] = 0;
            end else if (old_tick) begin
               m_seen[g]++;
               m_pulse[g] = ((m_seen[g] % lim_of(m_gran[g])) == 0);
            end else begin
               m_pulse[g] = 0;
            end
         end
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin
                  if (!wr_data[31] || !m_en) m_since = 0;
                  m_en  = wr_data[31];
                  m_val = int'(wr_data[15:0]);
               end
               2'd1: begin
                  m_sh[0] = int'(wr_data[5:0]);
                  m_sh[1] = int'(wr_data[13:8]);
                  m_sh[2] = int'(wr_data[21:16]);
                  m_sel   = wr_data[24];
               end
               2'd2: for (int g = 0; g < 3; g++) m_gran[g] = int'(wr_data[2*g +: 2]);
               default: ;
            endcase
         end
      end
   end

   task automatic cmp(input string req, input longint unsigned act, input longint unsigned exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (!done && cycles > 0) begin
         string rq;
         longint unsigned exp_log;
         exp_log = m_sel ? stamp_of(m_raw, m_sh[2]) : ((m_raw / REF_MS) & 64'hFFFF_FFFF);
         rq = rst ? "R9" : "";
         cmp({"R1 ts_raw ", rq}, ts_raw, m_raw);
         cmp({"R2 ts_tag ", rq}, ts_tag, stamp_of(m_raw, m_sh[0]));
         cmp({"R2 ts_nat ", rq}, ts_nat, stamp_of(m_raw, m_sh[1]));
         cmp({"R3 ts_log ", rq}, ts_log, exp_log);
         cmp({"R5 common_tick ", phase}, common_tick, m_tick);
         for (int g = 0; g < 3; g++)
            cmp({"R6 pulse ", phase}, pulse[g], m_pulse[g]);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 32'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      wait (cycles > WATCHDOG);
      n_bad++;
      $display("FAIL watchdog R1 act=%0d exp<%0d", cycles, WATCHDOG);
      finish_run();
   end

   initial begin
      idle(4);
      rst = 1'b0;
      phase = "R1";
      idle(30);
      // R2 R3: tag shift 3, translation shift 63, log shifted by 2
      phase = "R2";
      wr(2'd1, 32'd3 | (32'd63 << 8) | (32'd2 << 16) | (32'd1 << 24));
      idle(60);
      // R2: shift 56 clears the tag stamp, log back to milliseconds
      wr(2'd1, 32'd56 | (32'd5 << 16));
      idle(40);
      // R5 R6: divide by 5, generators at 1, 10, 100 ticks
      phase = "R5";
      wr(2'd0, 32'd0);
      wr(2'd0, 32'd4);
      wr(2'd0, 32'd4 | (32'd1 << 31));
      wr(2'd2, 32'd0 | (32'd1 << 2) | (32'd2 << 4));
      idle(700);
      // R8: unused address
      phase = "R8";
      wr(2'd3, 32'hFFFF_FFFF);
      idle(100);
      // R7: only generator 1 changes
      phase = "R7";
      wr(2'd2, 32'd0 | (32'd0 << 2) | (32'd2 << 4));
      idle(300);
      // R4: divider off
      phase = "R4";
      wr(2'd0, 32'd4);
      idle(60);
      // R5: ratio one, generators 0 and 2 at 1000 ticks
      phase = "R5";
      wr(2'd0, 32'd0);
      wr(2'd0, 32'd1 << 31);
      wr(2'd2, 32'd3 | (32'd0 << 2) | (32'd3 << 4));
      idle(2500);
      // R7: unchanged word keeps counting
      phase = "R7";
      wr(2'd2, 32'd3 | (32'd0 << 2) | (32'd3 << 4));
      idle(1200);
      // R3: long run across millisecond boundaries, then shifted log
      phase = "R3";
      wr(2'd1, 32'd0 | (32'd14 << 8));
      idle(40000);
      wr(2'd1, (32'd14 << 16) | (32'd1 << 24));
      idle(200);
      finish_run();
   end

endmodule